// File: doc/BRIEF.md
# Fault-Triggered Waveform Capture Recorder

This block keeps a running record of current samples from a feeder and freezes a window around a fault. Each cycle it may receive one strobed set of signed samples: several phase currents and one ground current. While armed it writes every valid sample set into a circular store. For each channel it measures the size of the step from the previous valid sample. When any step is larger than the limit for its channel class, the block fires.

After firing, the block keeps writing until the post-fault part of the record is complete. It then raises a done flag and reports the store slot that holds the trigger sample. From then on it ignores new samples until it is re-armed.

The record always holds 5 cycles of history before the fault and 12 cycles after it. The cycle length in samples is picked at arm time: a standard rate or a high-resolution rate. For field use these parameters would be set to 128 and 512 samples per cycle. The defaults are smaller so that the store stays modest. Software reads the frozen record through an address/data port in time order, so offset 0 is always the oldest pre-fault sample.

Top module: `wcr_recorder`

## Requirements
- R1: On each valid sample, every channel compares the magnitude of its step from that channel's previous valid sample against a limit: `ph_lim` for phase channels and `gnd_lim` for ground. The previous valid sample includes one that arrives in a re-arm cycle. A step strictly above the limit on any channel is an exceedance; a step equal to the limit is not.
- R2: An exceedance fires the trigger only after PRE_C×SPC samples have been stored since the last arm. Earlier exceedances are ignored.
- R3: The frozen record is REC = (PRE_C+POST_C)×SPC samples long. It holds the PRE_C×SPC samples stored just before the trigger sample, then POST_C×SPC samples that begin with the trigger sample.
- R4: `hi_res` is sampled in the re-arm cycle. A value of 0 gives SPC = SPC_STD and a value of 1 gives SPC = SPC_HI. Reset selects SPC_STD.
- R5: Exceedances during post-trigger capture are ignored, and `trig_idx` keeps the slot of the first trigger.
- R6: `done` goes high right after the clock edge that stores the last post-trigger sample. It stays high until a re-arm. Samples that arrive while `done` is high leave the record unchanged.
- R7: From the trigger edge onward, `trig_idx` equals the number of samples stored since the arm before the trigger sample, modulo REC.
- R8: `rd_data` shows the record entry at time offset `rd_addr` (0 = oldest) after the next clock edge. The ground sample sits in the top DW bits. Phase k sits at bits [k×DW +: DW].
- R9: A re-arm clears `done` and restarts filling from slot 0. A sample that arrives in the same cycle is not stored.
- R10: After reset, `done` is 0, `trig_idx` is 0, the fill count is zero and the standard rate is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| ph_smp | input | PH_N×DW | Signed phase-current samples, phase k at [k×DW +: DW] |
| gnd_smp | input | DW | Signed ground-current sample |
| ph_lim | input | DW | Step limit for phase channels, per sample |
| gnd_lim | input | DW | Step limit for the ground channel, per sample |
| hi_res | input | 1 | Rate select, taken at re-arm |
| rearm | input | 1 | Release the frozen record and start a new fill |
| rd_addr | input | AW | Time offset into the frozen record |
| rd_data | output | (PH_N+1)×DW | Record entry, one cycle after `rd_addr` |
| done | output | 1 | Record complete and frozen |
| trig_idx | output | AW | Store slot of the trigger sample |

## Verification
The bench builds the recorder with two phase channels, 12-bit samples, and rates of 4 and 8 samples per cycle. These values give records of 68 and 136 entries, so both rate modes, wrap-around of the circular store, and the re-arm path all fit within a few thousand cycles. Limits of 20 and 10 let slow random drift stay below the trigger. Directed steps then hit the limit exactly, exceed it by one, and go in the negative direction.

// File: rtl/wcr_pkg.sv
package wcr_pkg;
  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_POST = 2'd1,
    ST_DONE = 2'd2
  } wcr_state_e;
endpackage

// File: rtl/wcr_slew.sv
module wcr_slew #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] lim,
  output logic          hit
);
  logic [DW-1:0] prev_q, prev_d;
  logic signed [DW:0] diff;
  logic [DW:0] mag;

  always_comb begin
    prev_d = vld ? x : prev_q;
    diff   = $signed({x[DW-1], x}) - $signed({prev_q[DW-1], prev_q});
    mag    = diff[DW] ? $unsigned(-diff) : $unsigned(diff);
    hit    = vld && (mag > {1'b0, lim});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  // R1: a flat step never counts as an exceedance
  p_flat_no_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && x == prev_q) |-> !hit);
endmodule

// File: rtl/wcr_ring.sv
module wcr_ring #(
  parameter int WW    = 32,
  parameter int DEPTH = 64,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wcr_ctrl.sv
module wcr_ctrl
  import wcr_pkg::*;
#(
  parameter int SPC_STD = 16,
  parameter int SPC_HI  = 64,
  parameter int PRE_C   = 5,
  parameter int POST_C  = 12,
  parameter int AW      = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic          hit,
  input  logic          hi_res,
  input  logic          rearm,
  input  logic [AW-1:0] rd_addr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          done,
  output logic [AW-1:0] trig_idx
);
  localparam logic [AW-1:0] PRE_LO  = AW'(PRE_C * SPC_STD);
  localparam logic [AW-1:0] PRE_HI  = AW'(PRE_C * SPC_HI);
  localparam logic [AW-1:0] POST_LO = AW'(POST_C * SPC_STD);
  localparam logic [AW-1:0] POST_HI = AW'(POST_C * SPC_HI);
  localparam logic [AW-1:0] REC_LO  = AW'((PRE_C + POST_C) * SPC_STD);
  localparam logic [AW-1:0] REC_HI  = AW'((PRE_C + POST_C) * SPC_HI);

  wcr_state_e    st_q, st_d;
  logic [AW-1:0] wp_q, wp_d, cnt_q, cnt_d, tix_q, tix_d;
  logic          hi_q, hi_d;
  logic [AW-1:0] pre_n, post_n, rec_n, wp_inc, rem;

  always_comb begin
    pre_n  = hi_q ? PRE_HI  : PRE_LO;
    post_n = hi_q ? POST_HI : POST_LO;
    rec_n  = hi_q ? REC_HI  : REC_LO;
    wp_inc = (wp_q == rec_n - 1'b1) ? '0 : wp_q + 1'b1;
    rem    = rec_n - wp_q;
    raddr  = (rd_addr >= rem) ? rd_addr - rem : wp_q + rd_addr;
  end

  always_comb begin
    st_d  = st_q;
    wp_d  = wp_q;
    cnt_d = cnt_q;
    hi_d  = hi_q;
    tix_d = tix_q;
    we    = 1'b0;
    if (rearm) begin
      st_d  = ST_FILL;
      wp_d  = '0;
      cnt_d = '0;
      hi_d  = hi_res;
    end else if (smp_vld) begin
      case (st_q)
        ST_FILL: begin
          we   = 1'b1;
          wp_d = wp_inc;
          if (cnt_q == pre_n && hit) begin
            st_d  = ST_POST;
            tix_d = wp_q;
            cnt_d = AW'(1);
          end else if (cnt_q != pre_n) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_POST: begin
          we    = 1'b1;
          wp_d  = wp_inc;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == post_n - 1'b1) st_d = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_FILL;
      wp_q  <= '0;
      cnt_q <= '0;
      hi_q  <= 1'b0;
      tix_q <= '0;
    end else begin
      st_q  <= st_d;
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
      tix_q <= tix_d;
    end
  end

  assign waddr    = wp_q;
  assign done     = (st_q == ST_DONE);
  assign trig_idx = tix_q;

  // R2: no trigger before the history window is full
  p_no_early_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL && cnt_q != pre_n) |=> st_q != ST_POST);
  // R3: the write slot stays inside the active record length
  p_wp_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q < rec_n);
  // R5: the trigger slot holds through post capture
  p_post_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POST && !rearm) |=> $stable(tix_q));
  // R6: a finished record stays frozen until re-armed
  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && !rearm) |=> (st_q == ST_DONE && $stable(wp_q)));
  // R9: re-arm restarts the fill from slot zero
  p_rearm_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (st_q == ST_FILL && wp_q == '0 && cnt_q == '0));
endmodule

// File: rtl/wcr_recorder.sv
module wcr_recorder #(
  parameter int DW      = 16,
  parameter int PH_N    = 3,
  parameter int SPC_STD = 16,
  parameter int SPC_HI  = 64,
  parameter int PRE_C   = 5,
  parameter int POST_C  = 12,
  localparam int NCH    = PH_N + 1,
  localparam int WW     = NCH * DW,
  localparam int DEPTH  = (PRE_C + POST_C) * SPC_HI,
  localparam int AW     = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_vld,
  input  logic [PH_N*DW-1:0] ph_smp,
  input  logic [DW-1:0]   gnd_smp,
  input  logic [DW-1:0]   ph_lim,
  input  logic [DW-1:0]   gnd_lim,
  input  logic            hi_res,
  input  logic            rearm,
  input  logic [AW-1:0]   rd_addr,
  output logic [WW-1:0]   rd_data,
  output logic            done,
  output logic [AW-1:0]   trig_idx
);
  logic [DW-1:0]  ch_x [NCH];
  logic [DW-1:0]  ch_l [NCH];
  logic [NCH-1:0] ch_hit;
  logic           we;
  logic [AW-1:0]  waddr, raddr;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g < PH_N) begin : g_ph
      assign ch_x[g] = ph_smp[g*DW +: DW];
      assign ch_l[g] = ph_lim;
    end else begin : g_gnd
      assign ch_x[g] = gnd_smp;
      assign ch_l[g] = gnd_lim;
    end
    wcr_slew #(.DW(DW)) i_slew (
      .clk (clk),
      .rst_n (rst_n),
      .vld (smp_vld),
      .x   (ch_x[g]),
      .lim (ch_l[g]),
      .hit (ch_hit[g])
    );
  end

  wcr_ctrl #(
    .SPC_STD (SPC_STD),
    .SPC_HI  (SPC_HI),
    .PRE_C   (PRE_C),
    .POST_C  (POST_C),
    .AW      (AW)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .hit      (|ch_hit),
    .hi_res   (hi_res),
    .rearm    (rearm),
    .rd_addr  (rd_addr),
    .we       (we),
    .waddr    (waddr),
    .raddr    (raddr),
    .done     (done),
    .trig_idx (trig_idx)
  );

  wcr_ring #(.WW(WW), .DEPTH(DEPTH), .AW(AW)) i_ring (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata ({gnd_smp, ph_smp}),
    .raddr (raddr),
    .rdata (rd_data)
  );
endmodule

// File: tb/test_wcr_recorder.sv
module test_wcr_recorder;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12, PH_N = 2, SPC_STD = 4, SPC_HI = 8, PRE_C = 5, POST_C = 12;
  localparam int NCH = PH_N + 1, WW = NCH * DW;
  localparam int DEPTH = (PRE_C + POST_C) * SPC_HI, AW = $clog2(DEPTH + 1);
  localparam int PH_LIM = 20, GND_LIM = 10;

  logic clk = 1'b0;
  logic rst_n, smp_vld, hi_res, rearm, done;
  logic [PH_N*DW-1:0] ph_smp;
  logic [DW-1:0] gnd_smp;
  logic [AW-1:0] rd_addr, trig_idx;
  logic [WW-1:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  wcr_recorder #(.DW(DW), .PH_N(PH_N), .SPC_STD(SPC_STD), .SPC_HI(SPC_HI),
                 .PRE_C(PRE_C), .POST_C(POST_C)) i_wcr_recorder (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .ph_smp(ph_smp), .gnd_smp(gnd_smp),
    .ph_lim(DW'(PH_LIM)), .gnd_lim(DW'(GND_LIM)), .hi_res(hi_res), .rearm(rearm),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .trig_idx(trig_idx));

  int checks = 0, errors = 0;
  int cur [NCH];
  int prv [NCH];
  int m_st = 0, m_n = 0, m_t = 0, m_post = 0, m_hi = 0;
  logic [WW-1:0] hist [4096];

  function automatic int pre_n();  return m_hi ? PRE_C*SPC_HI  : PRE_C*SPC_STD;  endfunction
  function automatic int post_n(); return m_hi ? POST_C*SPC_HI : POST_C*SPC_STD; endfunction
  function automatic int rec_n();  return pre_n() + post_n(); endfunction
  function automatic logic [WW-1:0] pack();
    return {DW'(cur[2]), DW'(cur[1]), DW'(cur[0])};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // Reference behaviour written from R1..R9
  function automatic void model_step(bit vld, bit re, int hi);
    bit hit = 1'b0;
    logic [WW-1:0] w = pack();
    if (vld) begin
      for (int k = 0; k < NCH; k++) begin
        int d = cur[k] - prv[k];
        if (d < 0) d = -d;
        if (d > ((k < PH_N) ? PH_LIM : GND_LIM)) hit = 1'b1;
        prv[k] = cur[k];
      end
    end
    if (re) begin
      m_st = 0; m_n = 0; m_hi = hi;
    end else if (vld) begin
      if (m_st == 0) begin
        hist[m_n] = w;
        if (m_n >= pre_n() && hit) begin m_st = 1; m_t = m_n; m_post = 1; end
        m_n++;
      end else if (m_st == 1) begin
        hist[m_n] = w;
        m_n++; m_post++;
        if (m_post == post_n()) m_st = 2;
      end
    end
  endfunction

  task automatic tick(bit vld, bit re = 1'b0, int hi = 0);
    smp_vld = vld; rearm = re; hi_res = hi[0];
    ph_smp  = {DW'(cur[1]), DW'(cur[0])};
    gnd_smp = DW'(cur[2]);
    model_step(vld, re, hi);
    @(negedge clk);
    smp_vld = 1'b0; rearm = 1'b0;
    chk("R6 R9 done flag", {63'd0, done}, {63'd0, m_st == 2});
    if (m_st != 0) chk("R5 R7 trigger slot", trig_idx, AW'(m_t % rec_n()));
  endtask

  task automatic quiet(int n);
    for (int i = 0; i < n; i++) begin
      bit v = ($urandom_range(3) != 0);
      if (v) begin
        for (int k = 0; k < NCH; k++) begin
          cur[k] += int'($urandom_range(6)) - 3;
          if (cur[k] > 1500) cur[k] = 1500;
          if (cur[k] < -1500) cur[k] = -1500;
        end
      end
      tick(v);
    end
  endtask

  task automatic step(int ch, int delta);
    cur[ch] += delta;
    tick(1'b1);
  endtask

  task automatic fill_to(int n);
    for (int g = 0; g < 4000 && m_n < n; g++) quiet(1);
  endtask

  task automatic finish_post();
    for (int g = 0; g < 4000 && m_st == 1; g++) quiet(1);
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < rec_n(); i++) begin
      rd_addr = AW'(i);
      @(negedge clk);
      chk(tag, rd_data, hist[m_t - pre_n() + i]);
    end
    rd_addr = AW'(pre_n());
    @(negedge clk);
    chk("R3 trigger sample sits after the history", rd_data, hist[m_t]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4711);
    rst_n = 1'b0; smp_vld = 1'b0; rearm = 1'b0; hi_res = 1'b0;
    ph_smp = '0; gnd_smp = '0; rd_addr = '0;
    for (int k = 0; k < NCH; k++) begin cur[k] = 0; prv[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 done after reset", {63'd0, done}, 64'd0);
    chk("R10 trig_idx after reset", trig_idx, '0);

    // Standard rate from reset: early jump (R2), exact-limit step (R1), negative trigger
    quiet(8);
    step(0, 200);
    step(0, -200);
    fill_to(pre_n() + 3);
    step(1, PH_LIM);
    step(1, -PH_LIM);
    quiet(4);
    step(0, -(PH_LIM + 1));
    chk("R1 R2 negative step fired after fill", {63'd0, m_st != 0}, 64'd1);
    step(2, 300);   // R5 ignored during post
    step(2, -300);
    finish_post();
    chk("R6 done after standard capture", {63'd0, done}, 64'd1);
    read_all("R3 R8 standard record");
    quiet(20);
    step(0, 250);
    read_all("R6 frozen record");

    // High-resolution arm with a sample in the rearm cycle (R9, R4), ground trigger
    cur[2] += 300;
    tick(1'b1, 1'b1, 1);
    fill_to(pre_n());
    step(2, GND_LIM + 1);
    chk("R1 R4 ground step fired in high rate", {63'd0, m_st != 0}, 64'd1);
    finish_post();
    read_all("R4 R3 R8 high-rate record");

    // Standard rate with long fill so the ring wraps (R7)
    tick(1'b0, 1'b1, 0);
    fill_to(150);
    step(1, 400);
    finish_post();
    read_all("R7 R3 wrapped record");

    // Random runs with random rate, gaps and near-limit steps
    for (int it = 0; it < 4; it++) begin
      tick($urandom_range(1) != 0, 1'b1, int'($urandom_range(1)));
      for (int g = 0; g < 3000 && m_st != 2; g++) begin
        if ($urandom_range(24) == 0) begin
          int c = int'($urandom_range(NCH - 1));
          int mag = int'($urandom_range(40)) + 1;
          step(c, ($urandom_range(1) != 0) ? mag : -mag);
        end else begin
          quiet(1);
        end
      end
      if (m_st == 2) read_all("R3 R8 random record");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule